// File: doc/BRIEF.md
# Processor-Side Bus Arbitration Controller

This block sits inside a processor that masters a shared external bus and decides when that bus may be handed to an outside master. An outside master requests the bus on one wire and confirms that it has taken over on another. The processor answers on a third wire, the grant. Both incoming wires are asynchronous. They pass through a synchronizer chain before the state machine looks at them.

Grant is held back while the processor is in the middle of something it cannot split. This covers a bus cycle in progress, an operand that still needs more bus cycles, and a locked read-modify-write sequence. It also covers one show-cycle setting. After the grant goes out, a release output tells the processor's address, data and control drivers to float. That output stays true until the outside master lets go. A stall output stops the internal cycle engine from starting new bus cycles while the bus is promised or lent out.

Top module: `bus_arb_ctrl`

## Requirements
- R1: An active-low synchronous reset leaves bus_grant, bus_hiz and core_stall low, and the processor owns the bus.
- R2: With release conditions met, a request raised on ext_req_a drives bus_grant and bus_hiz high on the third rising clock edge after it is applied.
- R3: Grant is withheld while cyc_busy is high. It is also withheld inside a multi-cycle operand. The operand opens when cyc_done is seen with cyc_last low and closes when cyc_done is seen with cyc_last high.
- R4: Grant is withheld while rmw_lock is high.
- R5: Grant is withheld while show_mode equals 2'b01. The other show_mode codes do not block it.
- R6: If the request falls while grant is out and no acknowledge has been seen, grant and bus_hiz both fall and the processor keeps the bus.
- R7: An acknowledge raised on ext_ack_a drops bus_grant on the third rising edge after it is applied, while bus_hiz stays high.
- R8: When acknowledge falls and no request is pending, bus_hiz falls on the third rising edge after the acknowledge input falls.
- R9: A request still high when acknowledge falls, with release conditions met, brings bus_grant back high, and bus_hiz never falls in between.
- R10: core_stall is high whenever bus_grant or bus_hiz is high. It is also high when the synchronized request is seen and release conditions are met, which is one edge before grant rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_req_a | input | 1 | Asynchronous bus request from outside masters (wire-OR, active high) |
| ext_ack_a | input | 1 | Asynchronous grant acknowledge from the outside master (active high) |
| cyc_busy | input | 1 | A processor bus cycle is in progress |
| cyc_done | input | 1 | The current bus cycle terminates this clock |
| cyc_last | input | 1 | The terminating cycle is the last one of its operand |
| rmw_lock | input | 1 | Locked read-modify-write sequence active |
| show_mode | input | 2 | Show-cycle setting; 2'b01 forbids external grant |
| bus_grant | output | 1 | Grant to the outside master |
| bus_hiz | output | 1 | Release processor address, data and control drivers |
| core_stall | output | 1 | Hold the cycle engine from starting a bus cycle |

## Verification
Each input change reaches an output after a set number of edges. Request and acknowledge pass two synchronizer flops and one state register, so grant rises, grant falls and bus_hiz falls on the third rising edge after the input moves. core_stall reacts on the second edge, because it also decodes the synchronized request combinationally. The vector walk holds each input pattern for four cycles so that every pipeline has settled before sampling. The directed tests then sample at the second and third edge after a change, which shows that each result neither comes early nor comes late.

// File: rtl/arb_pkg.sv
// Package: shared types and codes for the bus arbitration controller.
// Assumes: a two-bit show-cycle setting field.
package arb_pkg;

    // Who drives the external bus, as seen by the arbitration FSM.
    typedef enum logic [1:0] {
        ST_OWN   = 2'b00,   // processor is master
        ST_GRANT = 2'b01,   // grant out, waiting for acknowledge
        ST_EXT   = 2'b10    // outside master holds the bus
    } arb_state_e;

    localparam int          SHOW_W       = 2;
    localparam logic [1:0]  SHOW_NOGRANT = 2'b01;

endpackage

// File: rtl/arb_sync.sv
// Module: arb_sync
// Multi-flop synchronizer for asynchronous single-bit-per-lane inputs.
// Assumes: STAGES >= 1; each lane is an independent level, not a pulse
// shorter than one clock.
module arb_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);

    logic [STAGES-1:0][WIDTH-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the asynchronous level into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= '0;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                // Shift the level one stage further along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/arb_gate.sv
// Module: arb_gate
// Decides whether the processor may let go of the bus right now.
// It tracks whether a multi-cycle operand is still open and combines that
// with the in-progress, lock and show-cycle inputs.
// Assumes: cyc_done is asserted for the clock in which a bus cycle ends and
// cyc_last qualifies it.
module arb_gate
    import arb_pkg::*;
#(
    parameter int                SW         = SHOW_W,
    parameter logic [SW-1:0]     BLOCK_CODE = SHOW_NOGRANT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_busy,
    input  logic          cyc_done,
    input  logic          cyc_last,
    input  logic          rmw_lock,
    input  logic [SW-1:0] show_mode,
    output logic          release_ok
);

    logic xfer_open;

    // Remember that an operand still has cycles left after a non-final end.
    always_ff @(posedge clk) begin
        if (!rst_n)        xfer_open <= 1'b0;
        else if (cyc_done) xfer_open <= !cyc_last;
    end

    // Release only at an operand boundary, outside locks, in a permitting mode.
    always_comb begin
        release_ok = !cyc_busy && !xfer_open && !rmw_lock
                     && (show_mode != BLOCK_CODE);
    end

    // R3: a partial operand end closes the window on the next clock
    a_r3_partial_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && !cyc_last) |=> !release_ok);

endmodule

// File: rtl/arb_fsm.sv
// Module: arb_fsm
// Arbitration state machine driving grant, driver release and core stall.
// Assumes: req_s and ack_s are already synchronized; release_ok is a
// combinational qualifier valid every clock.
module arb_fsm
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_s,
    input  logic ack_s,
    input  logic release_ok,
    output logic grant,
    output logic hiz,
    output logic stall
);

    arb_state_e state_q, state_d;

    // Next-state selection from synchronized handshake and release qualifier.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN: begin
                if (req_s && release_ok) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                if (ack_s)       state_d = ST_EXT;
                else if (!req_s) state_d = ST_OWN;
            end
            ST_EXT: begin
                if (!ack_s) state_d = (req_s && release_ok) ? ST_GRANT : ST_OWN;
            end
            default: state_d = ST_OWN;
        endcase
    end

    // State and registered output flags, updated together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OWN;
            grant   <= 1'b0;
            hiz     <= 1'b0;
        end else begin
            state_q <= state_d;
            grant   <= (state_d == ST_GRANT);
            hiz     <= (state_d != ST_OWN);
        end
    end

    // Stall while lent, and one clock early when a grant is about to go out.
    always_comb begin
        stall = hiz || ((state_q == ST_OWN) && req_s && release_ok);
    end

    // R1: reset clears grant and release
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!grant && !hiz));

    // R7: acknowledge seen ends the grant, drivers stay released
    a_r7_ack_drops_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT && ack_s) |=> (!grant && hiz));

    // R6: withdrawn request returns the bus to the processor
    a_r6_withdraw_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GRANT && !ack_s && !req_s) |=> (!grant && !hiz));

    // R8: acknowledge negated with nothing pending retakes the bus
    a_r8_retake_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT && !ack_s && !req_s) |=> !hiz);

    // R9: pending request at acknowledge negation regrants without retaking
    a_r9_requeue_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT && !ack_s && req_s && release_ok) |=> (grant && hiz));

endmodule

// File: rtl/bus_arb_ctrl.sv
// Module: bus_arb_ctrl (top)
// Bus arbitration controller: synchronizes the external handshake,
// qualifies release against the processor's transfer status, and runs the
// arbitration FSM.
// Assumes: handshake inputs are active high and asynchronous; transfer
// status inputs are synchronous to clk.
module bus_arb_ctrl
    import arb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_req_a,
    input  logic              ext_ack_a,
    input  logic              cyc_busy,
    input  logic              cyc_done,
    input  logic              cyc_last,
    input  logic              rmw_lock,
    input  logic [SHOW_W-1:0] show_mode,
    output logic              bus_grant,
    output logic              bus_hiz,
    output logic              core_stall
);

    localparam int HS_LANES = 2;

    logic [HS_LANES-1:0] hs_sync;
    logic                release_ok;

    arb_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (HS_LANES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({ext_ack_a, ext_req_a}),
        .q_sync  (hs_sync)
    );

    arb_gate #(
        .SW         (SHOW_W),
        .BLOCK_CODE (SHOW_NOGRANT)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_busy   (cyc_busy),
        .cyc_done   (cyc_done),
        .cyc_last   (cyc_last),
        .rmw_lock   (rmw_lock),
        .show_mode  (show_mode),
        .release_ok (release_ok)
    );

    arb_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (hs_sync[0]),
        .ack_s      (hs_sync[1]),
        .release_ok (release_ok),
        .grant      (bus_grant),
        .hiz        (bus_hiz),
        .stall      (core_stall)
    );

    // R3: grant never starts during a running bus cycle
    a_r3_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(!cyc_busy));

    // R4: grant never starts under a read-modify-write lock
    a_r4_no_grant_locked: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(!rmw_lock));

    // R5: grant never starts in the blocking show-cycle setting
    a_r5_no_grant_show: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> ($past(show_mode) != SHOW_NOGRANT));

    // R10: the cycle engine is held whenever the bus is promised or lent
    a_r10_stall_covers: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant || bus_hiz) |-> core_stall);

endmodule

// File: tb/bus_arb_ctrl_test.sv
`timescale 1ns/1ps
module bus_arb_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ext_req_a, ext_ack_a, cyc_busy, cyc_done, cyc_last, rmw_lock;
    logic [1:0] show_mode;
    logic       bus_grant, bus_hiz, core_stall;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bus_arb_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_req_a  (ext_req_a),
        .ext_ack_a  (ext_ack_a),
        .cyc_busy   (cyc_busy),
        .cyc_done   (cyc_done),
        .cyc_last   (cyc_last),
        .rmw_lock   (rmw_lock),
        .show_mode  (show_mode),
        .bus_grant  (bus_grant),
        .bus_hiz    (bus_hiz),
        .core_stall (core_stall)
    );

    // Vector: [14:11] requirement number, [10] req, [9] ack, [8] busy,
    // [7] done, [6] last, [5] lock, [4:3] show, [2:0] expected {grant,hiz,stall}
    // Each vector is held four cycles; outputs are then settled.
    localparam int NV = 18;
    localparam logic [14:0] VEC [0:NV-1] = '{
        15'b1010_0_0_0_0_0_0_00_000,  // R10 idle, no stall
        15'b0010_1_0_0_0_0_0_00_111,  // R2 request granted
        15'b0111_1_1_0_0_0_0_00_011,  // R7 acknowledged, grant low, released
        15'b0111_0_1_0_0_0_0_00_011,  // R7 still owned by outside master
        15'b1000_0_0_0_0_0_0_00_000,  // R8 acknowledge gone, bus retaken
        15'b0011_1_0_1_0_0_0_00_000,  // R3 busy cycle blocks grant
        15'b0010_1_0_0_0_0_0_00_111,  // R2 busy cleared, granted
        15'b0111_1_1_0_0_0_0_00_011,  // R7 acknowledged with request held
        15'b1001_1_0_0_0_0_0_00_111,  // R9 regrant after acknowledge drop
        15'b0110_0_0_0_0_0_0_00_000,  // R6 withdrawn before acknowledge
        15'b0011_0_0_0_1_0_0_00_000,  // R3 partial operand end
        15'b0011_1_0_0_0_0_0_00_000,  // R3 operand open blocks grant
        15'b0011_1_0_0_1_1_0_00_111,  // R3 final cycle closes operand
        15'b0110_0_0_0_0_0_0_00_000,  // R6 withdrawn again
        15'b0100_1_0_0_0_0_1_00_000,  // R4 lock blocks grant
        15'b0101_1_0_0_0_0_0_01_000,  // R5 blocking show code
        15'b0101_1_0_0_0_0_0_10_111,  // R5 other show code permits
        15'b0110_0_0_0_0_0_0_00_000   // R6 withdraw, back to idle
    };

    // Record one comparison and report a mismatch.
    task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Advance n rising edges and land on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [7:0] v);
        {ext_req_a, ext_ack_a, cyc_busy, cyc_done, cyc_last, rmw_lock, show_mode} = v;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(8'b0);
        step(3);
        // R1: reset state
        chk("R1 reset", {bus_grant, bus_hiz, core_stall}, 3'b000);
        rst_n = 1'b1;
        step(1);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][10:3]);
            step(4);
            chk($sformatf("R%0d vector %0d", VEC[i][14:11], i),
                {bus_grant, bus_hiz, core_stall}, VEC[i][2:0]);
        end

        // R2 / R10: stall on edge two, grant on edge three
        drive(8'b1000_0000);
        step(2);
        chk("R10 early stall", {bus_grant, core_stall}, 2'b01);
        step(1);
        chk("R2 grant on third edge", {bus_grant, bus_hiz}, 2'b11);

        // R7: acknowledge drops grant on edge three
        ext_ack_a = 1'b1;
        step(2);
        chk("R7 grant before third edge", {2'b0, bus_grant}, 3'b001);
        step(1);
        chk("R7 grant dropped", {bus_grant, bus_hiz}, 2'b01);

        // R9: request held, acknowledge falls; bus stays released
        step(2);
        ext_ack_a = 1'b0;
        for (int k = 0; k < 5; k++) begin
            step(1);
            chk("R9 hiz held", {2'b0, bus_hiz}, 3'b001);
        end
        chk("R9 regrant", {2'b0, bus_grant}, 3'b001);

        // R8: owned, request gone, acknowledge falls; retake on edge three
        ext_ack_a = 1'b1;
        ext_req_a = 1'b0;
        step(4);
        chk("R8 owned", {bus_grant, bus_hiz}, 2'b01);
        ext_ack_a = 1'b0;
        step(2);
        chk("R8 hiz before third edge", {2'b0, bus_hiz}, 3'b001);
        step(1);
        chk("R8 hiz released", {bus_grant, bus_hiz, core_stall}, 3'b000);

        // R1: reset while granted
        ext_req_a = 1'b1;
        step(4);
        chk("R1 pre-reset grant", {bus_grant, bus_hiz}, 2'b11);
        rst_n = 1'b0;
        step(1);
        chk("R1 reset from grant", {bus_grant, bus_hiz, core_stall}, 3'b000);
        drive(8'b0);
        rst_n = 1'b1;
        step(3);
        chk("R1 after reset", {bus_grant, bus_hiz, core_stall}, 3'b000);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule